// File: doc/BRIEF.md
# Quad-SPI Host to Asynchronous Bus Bridge

This block lets a fast host processor reach a slow asynchronous system bus through a 4-bit serial link. The bus uses an address strobe, two byte-lane strobes, a read/write line and a reply handshake. The host opens a frame by pulling chip select low. It then sends one nibble per rising edge of the serial clock. The first nibble is a command. The bridge decodes the frame into one read or one write on the bus. It runs that cycle on its own and keeps the result.

Results come back in a separate short frame, the poll. The bridge answers a poll with a status nibble and, after a read, with the data. The bridge keeps the address of the last accepted access. Step commands move that address up or down by the access size, so a run of linear accesses needs no address nibbles. The serial inputs are oversampled in the bridge clock domain, and the bus clock is the same clock.

Top module: `qspi_async_bus_bridge`

## Requirements
- R1: Command 0x1 writes with an address. Its frame is the command nibble, then AW/4 address nibbles, then a size nibble (0 = byte, 1 = word, 2 = long), then 2, 4 or 8 data nibbles. Command 0x2 reads with an address and has no data nibbles. Every multi-nibble field is sent most significant nibble first. A complete, accepted frame starts exactly one access at the given byte address.
- R2: Commands 0x3 and 0x5 write or read at the held address plus the access size in bytes (1, 2 or 4). Commands 0x4 and 0x6 do the same at the held address minus the size. Their frame is the command nibble, then the size nibble, then data nibbles for a write. Every accepted access, the misaligned ones included, loads its target into the held address.
- R3: Each word cycle follows this order on the bus. The address and read/write are valid one clock before the strobe falls and stay stable while it is low. The strobe stays low until the reply is sampled low, and rises on the next clock. With W wait clocks the strobe is low for W+2 clocks. The bridge drives data only on writes.
- R4: A byte access at an even address asserts only the upper lane strobe, on data bits 15:8. A byte access at an odd address asserts only the lower lane strobe, on bits 7:0. A word access asserts both lanes. A long access runs two word cycles, the high word at A and then the low word at A+2.
- R5: Command 0x8 is a poll. The nibble it returns has bit 0 = busy, bit 1 = done and bit 2 = error. When the last access was a read that completed without error, further nibbles follow with the read data, most significant nibble first (2, 4 or 8 of them). Otherwise the further nibbles are zero. Busy and done are never both set.
- R6: If the error input is low while the bridge waits for the reply, the cycle ends and the error bit is set. For a long access the second word cycle is skipped.
- R7: A word or long access at an odd address runs no bus cycle. It completes at once with done and error set.
- R8: An access frame that completes while the bridge is busy is ignored. Memory and the held address stay unchanged, and status bit 3 (overrun) is set. The next poll reports the overrun bit and clears it.
- R9: Raising chip select in the middle of a frame discards that frame. No access starts, and the next frame begins again with a command nibble.
- R10: Command codes 0x0, 0x7 and 0x9 to 0xF, and size codes 3 to 15, cause the rest of the frame to be ignored. No bus cycle starts and the status does not change.
- R11: After reset the bus is idle: all strobes are high, read/write shows read, and no output is driven on the bus or the link. A first poll returns status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge and bus clock |
| rst_n | input | 1 | Active-low reset |
| qspi_sck | input | 1 | Serial link clock, sampled |
| qspi_cs_n | input | 1 | Frame select, active low |
| qspi_din | input | 4 | Nibble from host |
| qspi_dout | output | 4 | Nibble to host during a poll |
| qspi_doe | output | 1 | Enable for qspi_dout |
| bus_addr | output | AW-1 | Word address (byte address bits AW-1:1) |
| bus_dout | output | 16 | Write data |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data |
| bus_strb_n | output | 1 | Address strobe, active low |
| bus_hi_n | output | 1 | Upper byte lane strobe, active low |
| bus_lo_n | output | 1 | Lower byte lane strobe, active low |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_ack_n | input | 1 | Cycle reply, active low |
| bus_err_n | input | 1 | Bus error reply, active low |

## Verification
Two things can land on the same clock edge. One is the snapshot a poll takes of the status. The other is the bus engine retiring an access and setting done. To make them meet, the bench sends a write and polls at once, and sweeps the wait states of the bus target from 0 to 30. That moves the completion edge across the poll's capture edge. Each poll must show exactly one of busy or done, never both and never neither. A later poll must then show done with no error and no overrun.

// File: rtl/qspi_async_bus_bridge.sv
module qspi_async_bus_bridge #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qspi_sck,
  input  logic          qspi_cs_n,
  input  logic [3:0]    qspi_din,
  output logic [3:0]    qspi_dout,
  output logic          qspi_doe,
  output logic [AW-1:1] bus_addr,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  output logic          bus_strb_n,
  output logic          bus_hi_n,
  output logic          bus_lo_n,
  output logic          bus_rd,
  input  logic          bus_ack_n,
  input  logic          bus_err_n
);
  localparam int AN = AW / 4;
  localparam int CW = $clog2(AN > 8 ? AN : 8);

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_SIZE, PH_DATA, PH_OUT, PH_SKIP} ph_t;
  typedef enum logic [2:0] {B_IDLE, B_ADDR, B_STRB, B_WAIT, B_END} bst_t;

  logic [1:0] sck_s, cs_s;
  logic [3:0] din_s0, din_s1;
  logic       sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= 2'b00; cs_s <= 2'b11; sck_q <= 1'b0;
      din_s0 <= '0; din_s1 <= '0;
    end else begin
      sck_s <= {sck_s[0], qspi_sck};
      cs_s  <= {cs_s[0], qspi_cs_n};
      sck_q <= sck_s[1];
      din_s0 <= qspi_din;
      din_s1 <= din_s0;
    end

  wire       sel  = ~cs_s[1];
  wire       rise = sel & sck_s[1] & ~sck_q;
  wire [3:0] nib  = din_s1;

  ph_t          ph;
  logic [3:0]   cmd;
  logic [AW-1:0] a_sr;
  logic [31:0]  d_sr;
  logic [1:0]   f_sz;
  logic [CW-1:0] cnt;
  logic         req;
  logic [35:0]  o_sr;

  bst_t         bst;
  logic [AW-1:0] held, cadr;
  logic [31:0]  wdat, rdat;
  logic [1:0]   sz;
  logic         rd, half, busy, done, berr, ovr, rvalid;

  wire wr_cmd = (cmd == 4'h1) | (cmd == 4'h3) | (cmd == 4'h4);
  wire poll   = rise & (ph == PH_CMD) & (nib == 4'h8);

  logic [31:0] rd_al;
  always_comb
    case (sz)
      2'd0:    rd_al = {rdat[7:0], 24'h0};
      2'd1:    rd_al = {rdat[15:0], 16'h0};
      default: rd_al = rdat;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= PH_CMD; cmd <= '0; a_sr <= '0; d_sr <= '0; f_sz <= '0;
      cnt <= '0; req <= 1'b0; o_sr <= '0;
    end else begin
      req <= 1'b0;
      if (!sel) ph <= PH_CMD;
      else if (rise)
        case (ph)
          PH_CMD: begin
            cmd <= nib;
            case (nib)
              4'h1, 4'h2: begin ph <= PH_ADDR; cnt <= CW'(AN - 1); end
              4'h3, 4'h4, 4'h5, 4'h6: ph <= PH_SIZE;
              4'h8: begin
                ph <= PH_OUT;
                o_sr <= {ovr, berr, done, busy, rvalid ? rd_al : 32'h0};
              end
              default: ph <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            a_sr <= {a_sr[AW-5:0], nib};
            if (cnt == '0) ph <= PH_SIZE;
            else cnt <= cnt - 1'b1;
          end
          PH_SIZE:
            if (nib > 4'd2) ph <= PH_SKIP;
            else begin
              f_sz <= nib[1:0];
              if (wr_cmd) begin
                ph <= PH_DATA; d_sr <= '0;
                cnt <= (CW'(2) << nib[1:0]) - 1'b1;
              end else begin
                req <= 1'b1; ph <= PH_SKIP;
              end
            end
          PH_DATA: begin
            d_sr <= {d_sr[27:0], nib};
            if (cnt == '0) begin req <= 1'b1; ph <= PH_SKIP; end
            else cnt <= cnt - 1'b1;
          end
          PH_OUT: o_sr <= {o_sr[31:0], 4'h0};
          default: ;
        endcase
    end

  wire [AW-1:0] step = AW'(1) << f_sz;
  logic [AW-1:0] tgt;
  always_comb
    case (cmd)
      4'h3, 4'h5: tgt = held + step;
      4'h4, 4'h6: tgt = held - step;
      default:    tgt = a_sr;
    endcase
  wire mis = (f_sz != 2'd0) & tgt[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bst <= B_IDLE; held <= '0; cadr <= '0; wdat <= '0; rdat <= '0;
      sz <= '0; rd <= 1'b1; half <= 1'b0; busy <= 1'b0; done <= 1'b0;
      berr <= 1'b0; ovr <= 1'b0; rvalid <= 1'b0;
    end else begin
      if (poll) ovr <= 1'b0;
      if (req) begin
        if (busy) ovr <= 1'b1;
        else begin
          held <= tgt; sz <= f_sz; rd <= ~wr_cmd; wdat <= d_sr;
          done <= 1'b0; berr <= 1'b0; rvalid <= 1'b0; rdat <= '0;
          if (mis) begin
            done <= 1'b1; berr <= 1'b1;
          end else begin
            busy <= 1'b1; cadr <= tgt; half <= 1'b0; bst <= B_ADDR;
          end
        end
      end
      case (bst)
        B_ADDR: bst <= B_STRB;
        B_STRB: bst <= B_WAIT;
        B_WAIT:
          if (!bus_err_n) begin berr <= 1'b1; bst <= B_END; end
          else if (!bus_ack_n) begin
            bst <= B_END;
            case (sz)
              2'd0: rdat <= {24'h0, cadr[0] ? bus_din[7:0] : bus_din[15:8]};
              2'd1: rdat <= {16'h0, bus_din};
              default:
                if (half) rdat[15:0] <= bus_din;
                else      rdat[31:16] <= bus_din;
            endcase
          end
        B_END:
          if (sz == 2'd2 && !half && !berr) begin
            half <= 1'b1; cadr <= cadr + AW'(2); bst <= B_ADDR;
          end else begin
            bst <= B_IDLE; busy <= 1'b0; done <= 1'b1; rvalid <= rd & ~berr;
          end
        default: ;
      endcase
    end

  wire act = (bst == B_STRB) | (bst == B_WAIT);

  assign bus_strb_n = ~act;
  assign bus_hi_n   = ~(act & ((sz != 2'd0) | ~cadr[0]));
  assign bus_lo_n   = ~(act & ((sz != 2'd0) | cadr[0]));
  assign bus_rd     = ~(busy & ~rd);
  assign bus_doe    = busy & ~rd;
  assign bus_addr   = cadr[AW-1:1];
  assign bus_dout   = (sz == 2'd0) ? {2{wdat[7:0]}} :
                      (sz == 2'd1 || half) ? wdat[15:0] : wdat[31:16];
  assign qspi_dout  = o_sr[35:32];
  assign qspi_doe   = sel & (ph == PH_OUT);
endmodule

// File: rtl/qspi_bridge_checker.sv
module qspi_bridge_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:1] bus_addr,
  input logic          bus_strb_n,
  input logic          bus_hi_n,
  input logic          bus_lo_n,
  input logic          bus_rd,
  input logic          bus_doe,
  input logic          bus_ack_n,
  input logic          bus_err_n,
  input logic          busy,
  input logic          done
);
  AST_LANE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hi_n || !bus_lo_n) |-> !bus_strb_n); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strb_n && $past(!bus_strb_n)) |-> ($stable(bus_addr) && $stable(bus_rd))); // R3
  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_strb_n) |-> ($stable(bus_addr) && $stable(bus_rd))); // R3
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rd); // R3
  AST_END_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strb_n) |-> (!$past(bus_ack_n) || !$past(bus_err_n))); // R3
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_strb_n && bus_rd && !bus_doe)); // R11
endmodule

bind qspi_async_bus_bridge qspi_bridge_checker #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strb_n(bus_strb_n),
  .bus_hi_n(bus_hi_n), .bus_lo_n(bus_lo_n), .bus_rd(bus_rd), .bus_doe(bus_doe),
  .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n), .busy(busy), .done(done)
);

// File: tb/qspi_async_bus_bridge_test.sv
`timescale 1ns/1ps
module qspi_async_bus_bridge_test;
  localparam int AW = 24;
  localparam int AN = AW / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic qspi_sck = 1'b0, qspi_cs_n = 1'b1;
  logic [3:0] qspi_din = 4'h0, qspi_dout;
  logic qspi_doe;
  logic [AW-1:1] bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic bus_doe, bus_strb_n, bus_hi_n, bus_lo_n, bus_rd;
  logic ack_n = 1'b1, err_n = 1'b1;

  always #2.5 clk = ~clk;

  qspi_async_bus_bridge #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .qspi_sck(qspi_sck), .qspi_cs_n(qspi_cs_n),
    .qspi_din(qspi_din), .qspi_dout(qspi_dout), .qspi_doe(qspi_doe),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_strb_n(bus_strb_n), .bus_hi_n(bus_hi_n), .bus_lo_n(bus_lo_n),
    .bus_rd(bus_rd), .bus_ack_n(ack_n), .bus_err_n(err_n)
  );

  int n_cmp = 0, n_bad = 0;
  int wst = 0, tcnt = 0;
  logic [7:0] tmem [0:127];
  logic [7:0] rmem [0:127];

  assign bus_din = {tmem[{bus_addr[6:1], 1'b0}], tmem[{bus_addr[6:1], 1'b1}]};

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) tmem[i] <= 8'((i * 37 + 5) & 255);
      ack_n <= 1'b1; err_n <= 1'b1; tcnt <= 0;
    end else if (bus_strb_n) begin
      ack_n <= 1'b1; err_n <= 1'b1; tcnt <= 0;
    end else if (ack_n && err_n) begin
      if (tcnt == wst) begin
        if (bus_addr[AW-1]) err_n <= 1'b0;
        else begin
          ack_n <= 1'b0;
          if (!bus_rd) begin
            if (!bus_hi_n) tmem[{bus_addr[6:1], 1'b0}] <= bus_dout[15:8];
            if (!bus_lo_n) tmem[{bus_addr[6:1], 1'b1}] <= bus_dout[7:0];
          end
        end
      end else tcnt <= tcnt + 1;
    end

  int mon_cyc = 0, mon_badlen = 0, run = 0;
  logic mon_hi, mon_lo, mon_rd, prev_strb = 1'b1;
  logic [AW-1:1] mon_a1, mon_a2;
  always @(negedge clk) begin
    if (!bus_strb_n) begin
      if (prev_strb) begin
        mon_cyc++;
        if (mon_cyc == 1) begin
          mon_hi = bus_hi_n; mon_lo = bus_lo_n; mon_a1 = bus_addr; mon_rd = bus_rd;
        end else mon_a2 = bus_addr;
        run = 1;
      end else run++;
    end else if (!prev_strb && run != wst + 2) mon_badlen++;
    prev_strb = bus_strb_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic nib(input logic [3:0] v);
    qspi_din = v; qspi_sck = 1'b0;
    repeat (4) @(negedge clk);
    qspi_sck = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic begin_f;
    qspi_cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_f;
    repeat (2) @(negedge clk);
    qspi_sck = 1'b0;
    repeat (2) @(negedge clk);
    qspi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_addr(input logic [AW-1:0] a);
    for (int i = AN - 1; i >= 0; i--) nib(a[4*i +: 4]);
  endtask

  task automatic access(input logic [3:0] c, input logic [AW-1:0] a, input logic [1:0] s,
                        input logic [31:0] d);
    begin_f;
    nib(c);
    if (c == 4'h1 || c == 4'h2) send_addr(a);
    nib({2'b00, s});
    if (c == 4'h1 || c == 4'h3 || c == 4'h4)
      for (int i = (2 << s) - 1; i >= 0; i--) nib(d[4*i +: 4]);
    end_f;
  endtask

  task automatic poll(output logic [3:0] st, output logic [31:0] d, input int nd);
    begin_f;
    nib(4'h8);
    st = qspi_dout;
    d = '0;
    for (int i = 0; i < nd; i++) begin
      nib(4'h0);
      d = {d[27:0], qspi_dout};
    end
    end_f;
  endtask

  task automatic wait_done(output logic [3:0] st);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      poll(st, d, 0);
      if (!st[0]) break;
    end
  endtask

  task automatic mon_clear;
    mon_cyc = 0; mon_badlen = 0;
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 128; i++) if (tmem[i] !== rmem[i]) n++;
    return n;
  endfunction

  logic [AW-1:0] held_ref = '0;

  task automatic run_case(input logic [3:0] c, input logic [AW-1:0] a, input logic [1:0] s,
                          input logic [31:0] draw);
    logic [AW-1:0] t;
    logic [31:0] d, exp_d, got_d;
    logic [3:0] st;
    bit is_wr, mis, reg_err;
    int nb, exp_cyc;
    string atag;
    nb = 1 << s;
    d = (s == 0) ? {24'h0, draw[7:0]} : (s == 1) ? {16'h0, draw[15:0]} : draw;
    is_wr = (c == 4'h1 || c == 4'h3 || c == 4'h4);
    case (c)
      4'h3, 4'h5: t = held_ref + AW'(nb);
      4'h4, 4'h6: t = held_ref - AW'(nb);
      default:    t = a;
    endcase
    atag = (c == 4'h1 || c == 4'h2) ? "R1" : "R2";
    held_ref = t;
    mis = (s != 0) && t[0];
    reg_err = t[AW-1];
    exp_cyc = mis ? 0 : reg_err ? 1 : (s == 2 ? 2 : 1);
    exp_d = '0;
    for (int k = 0; k < nb; k++) exp_d = {exp_d[23:0], rmem[(int'(t[6:0]) + k) & 127]};
    if (is_wr && !mis && !reg_err)
      for (int k = 0; k < nb; k++) rmem[(int'(t[6:0]) + k) & 127] = d[8*(nb-1-k) +: 8];
    mon_clear;
    access(c, a, s, d);
    wait_done(st);
    poll(st, got_d, (!is_wr && !mis && !reg_err) ? 2 * nb : 0);
    chk(st == {1'b0, mis | reg_err, 2'b10}, mis ? "R7" : reg_err ? "R6" : "R5",
        64'(st), 64'({1'b0, mis | reg_err, 2'b10}));
    if (!is_wr && !mis && !reg_err) chk(got_d == exp_d, atag, 64'(got_d), 64'(exp_d));
    chk(mon_cyc == exp_cyc, mis ? "R7" : reg_err ? "R6" : "R4", 64'(mon_cyc), 64'(exp_cyc));
    chk(mon_badlen == 0, "R3", 64'(mon_badlen), 64'(0));
    if (exp_cyc > 0) begin
      chk(mon_a1 == t[AW-1:1], atag, 64'(mon_a1), 64'(t[AW-1:1]));
      chk(mon_rd == !is_wr, "R3", 64'(mon_rd), 64'(!is_wr));
      if (s == 0) chk({mon_hi, mon_lo} == {t[0], ~t[0]}, "R4", 64'({mon_hi, mon_lo}), 64'({t[0], ~t[0]}));
      else        chk({mon_hi, mon_lo} == 2'b00, "R4", 64'({mon_hi, mon_lo}), 64'(0));
    end
    if (exp_cyc == 2) chk(mon_a2 == t[AW-1:1] + 1'b1, "R4", 64'(mon_a2), 64'(t[AW-1:1] + 1'b1));
    if (is_wr) chk(mem_diff() == 0, atag, 64'(mem_diff()), 64'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    report;
    $finish;
  end

  initial begin
    logic [3:0] st;
    logic [31:0] d;
    logic [3:0] cl [0:5];
    int it;
    cl[0] = 4'h1; cl[1] = 4'h2; cl[2] = 4'h3; cl[3] = 4'h5; cl[4] = 4'h4; cl[5] = 4'h6;
    for (int i = 0; i < 128; i++) rmem[i] = 8'((i * 37 + 5) & 255);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk({bus_strb_n, bus_hi_n, bus_lo_n, bus_rd} == 4'hF && !bus_doe && !qspi_doe, "R11",
        64'({bus_strb_n, bus_hi_n, bus_lo_n, bus_rd, bus_doe, qspi_doe}), 64'h3C);
    poll(st, d, 0);
    chk(st == 4'h0, "R11", 64'(st), 64'(0));

    it = 0;
    foreach (cl[ci]) ;
    for (int w = 0; w < 3; w++) begin
      wst = (w == 2) ? 3 : w;
      for (int s = 0; s < 3; s++)
        for (int ci = 0; ci < 6; ci++)
          for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a;
            a = AW'(((k * 13 + s * 5 + wst + ci * 7) & 127));
            if (k == 3) a[AW-1] = 1'b1;
            run_case(cl[ci], a, 2'(s), 32'h9E3779B9 * 32'(it + 1));
            it++;
          end
    end

    // R8: overrun while a slow access is in flight
    wst = 400;
    held_ref = AW'(16);
    rmem[16] = 8'hAB; rmem[17] = 8'hCD;
    mon_clear;
    access(4'h1, AW'(16), 2'd1, 32'hABCD);
    access(4'h1, AW'(32), 2'd1, 32'h1234);
    poll(st, d, 0);
    chk(st == 4'b1001, "R8", 64'(st), 64'(4'b1001));
    wait_done(st);
    chk(st == 4'b0010, "R8", 64'(st), 64'(4'b0010));
    chk(mon_cyc == 1, "R8", 64'(mon_cyc), 64'(1));
    chk(mem_diff() == 0, "R8", 64'(mem_diff()), 64'(0));
    wst = 0;
    run_case(4'h5, '0, 2'd1, 32'h0);
    chk(mon_a1 == AW'(18) >> 1, "R8", 64'(mon_a1), 64'(9));

    // R5: poll snapshot against completion edge
    for (int dly = 0; dly <= 30; dly++) begin
      logic [AW-1:0] a;
      a = AW'(64 + 2 * (dly % 8));
      wst = dly;
      rmem[a] = 8'(dly); rmem[a + 1] = 8'(dly * 3);
      access(4'h1, a, 2'd1, {16'h0, 8'(dly), 8'(dly * 3)});
      poll(st, d, 0);
      chk(st == 4'b0001 || st == 4'b0010, "R5", 64'(st), 64'(4'b0010));
      wait_done(st);
      chk(st == 4'b0010, "R5", 64'(st), 64'(4'b0010));
    end
    held_ref = AW'(64 + 2 * (30 % 8));
    chk(mem_diff() == 0, "R1", 64'(mem_diff()), 64'(0));

    // R9: frame cut short by chip select
    wst = 1;
    mon_clear;
    begin_f; nib(4'h1); nib(4'h0); nib(4'h0); end_f;
    poll(st, d, 0);
    chk(st == 4'b0010 && mon_cyc == 0, "R9", 64'({st, 4'(mon_cyc)}), 64'h20);
    run_case(4'h2, AW'(5), 2'd0, 32'h0);
    chk(mon_cyc == 1, "R9", 64'(mon_cyc), 64'(1));

    // R10: undefined command and size codes
    mon_clear;
    begin_f; nib(4'h7); nib(4'h1); nib(4'h2); nib(4'h3); end_f;
    begin_f; nib(4'h1); send_addr(AW'(48)); nib(4'h3);
    nib(4'hF); nib(4'hF); nib(4'hF); nib(4'hF); end_f;
    begin_f; nib(4'h3); nib(4'h9); nib(4'hE); nib(4'hE); end_f;
    poll(st, d, 2);
    chk(mon_cyc == 0, "R10", 64'(mon_cyc), 64'(0));
    chk(st == 4'b0010, "R10", 64'(st), 64'(4'b0010));
    chk(d[7:0] == rmem[5], "R10", 64'(d[7:0]), 64'(rmem[5]));
    chk(mem_diff() == 0, "R10", 64'(mem_diff()), 64'(0));

    report;
    $finish;
  end
endmodule